// File: doc/BRIEF.md
# Word-to-Byte FIFO Data Port

This block sits between a 32-bit register interface and the two byte-wide queues of a SPI host. A transmit-data write is broken into four bytes, which go into the transmit queue lowest byte first. A receive-data read pulls up to four bytes from the receive queue and packs them into one word, again lowest byte first. The serial shifter uses the other side of each queue. It pops transmit bytes and pushes received bytes, one byte per cycle.

Each word access takes four clock cycles, one byte per cycle, and `bus_ready` stays low until the access is complete. The block reports the full and empty state of each queue and its depth in whole words. When a write finds the transmit queue full, it raises a one-cycle overflow pulse for the error logic. When a read finds the receive queue empty, it raises a one-cycle underflow pulse. A software reset or the end of a segment can drive a separate flush input for each queue.

Top module: `spi_word_port`

## Requirements
- R1: After reset, both queues are empty (`tx_empty`=1, `rx_empty`=1, `tx_full`=0, `rx_full`=0, `tx_words`=0, `rx_words`=0), `bus_ready` is 1 and both error pulses are 0.
- R2: An accepted write enqueues `wr_data[7:0]`, then `[15:8]`, then `[23:16]`, then `[31:24]`, and the shifter pops them in that order from `tx_byte`.
- R3: If the transmit queue is full when a byte of a write is due, that byte and every later byte of the same word are dropped, even if space frees up meanwhile. `tx_full` reads 1 and `err_overflow` is high for exactly one cycle per affected write.
- R4: An accepted read places the bytes it pops into `rd_data[7:0]`, `[15:8]`, `[23:16]` and `[31:24]`, in pop order.
- R5: If the receive queue is empty when a byte of a read is due, that lane and every later lane read as zero, even if bytes arrive meanwhile. `rx_empty` reads 1 and `err_underflow` is high for exactly one cycle per affected read.
- R6: A read from a full receive queue deasserts `rx_full` once the read completes.
- R7: Asserting `flush_tx` or `flush_rx` for one cycle empties that queue on the next edge: empty=1, full=0, depth 0.
- R8: `tx_words` and `rx_words` equal the queue's byte count plus three, divided by four and rounded down. A partly filled word therefore counts as a whole word.
- R9: `bus_ready` goes low on the edge that accepts a request and stays low for exactly four cycles. Requests raised while it is low have no effect.
- R10: If `wr_req` and `rd_req` are both high in the accept cycle, the write is carried out and the read is dropped; the receive queue is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush_tx | input | 1 | Empty the transmit queue |
| flush_rx | input | 1 | Empty the receive queue |
| wr_req | input | 1 | Transmit-data word write request |
| wr_data | input | 32 | Word to enqueue |
| rd_req | input | 1 | Receive-data word read request |
| rd_data | output | 32 | Word assembled by the last read |
| bus_ready | output | 1 | High when a new access can be accepted |
| tx_pop | input | 1 | Shifter takes one transmit byte |
| tx_byte | output | 8 | Oldest transmit byte |
| rx_push | input | 1 | Shifter delivers one received byte |
| rx_byte | input | 8 | Received byte |
| tx_full | output | 1 | Transmit queue full |
| tx_empty | output | 1 | Transmit queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_empty | output | 1 | Receive queue empty |
| tx_words | output | 8 | Transmit depth in words, rounded up |
| rx_words | output | 8 | Receive depth in words, rounded up |
| err_overflow | output | 1 | One-cycle pulse when a write drops bytes |
| err_underflow | output | 1 | One-cycle pulse when a read runs dry |

## Verification
A request accepted on edge E0 moves byte k on edge E(k+1). `bus_ready` therefore reads low at the four falling edges after E0 and high again after E4. `rd_data`, the queue flags and the word depths are final after E4. An error pulse is registered on the edge where the first byte is refused and falls one edge later. A flush or a single shifter push or pop shows in the status outputs one edge after it is driven. The bench drives every input at a falling edge and samples at the next falling edge. It counts the low `bus_ready` cycles itself. It reads the pulse counters only one falling edge after `bus_ready` returns, so a pulse on the final edge has already been counted.

// File: rtl/spi_port_pkg.sv
`timescale 1ns/1ps
package spi_port_pkg;
    localparam int BYTES_PER_WORD = 4;
    localparam int BYTE_W         = 8;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_READ  = 2'd2
    } acc_kind_e;
endpackage

// File: rtl/spi_byte_ring.sv
`timescale 1ns/1ps
module spi_byte_ring #(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [7:0]    push_byte,
    input  logic          pop,
    output logic [7:0]    head_byte,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] level;
    } ring_t;

    ring_t st_d, st_q;
    logic  do_push, do_pop;
    logic [7:0] mem [DEPTH];

    always_comb begin
        do_push = push && (st_q.level != CW'(DEPTH));
        do_pop  = pop  && (st_q.level != '0);
        st_d    = st_q;
        if (flush) begin
            st_d = '0;
        end else begin
            if (do_push) st_d.wr_ptr = st_q.wr_ptr + 1'b1;
            if (do_pop)  st_d.rd_ptr = st_q.rd_ptr + 1'b1;
            st_d.level = st_q.level + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[st_q.wr_ptr] <= push_byte;
    end

    assign head_byte = mem[st_q.rd_ptr];
    assign level     = st_q.level;
    assign full      = (st_q.level == CW'(DEPTH));
    assign empty     = (st_q.level == '0);

    // R7
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (empty && !full));

    // R3
    full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !flush) |=> $stable(st_q.level));
endmodule

// File: rtl/spi_word_seq.sv
`timescale 1ns/1ps
module spi_word_seq
    import spi_port_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_req,
    input  logic [31:0] wr_data,
    input  logic        rd_req,
    input  logic        tx_full,
    output logic        tx_push,
    output logic [7:0]  tx_byte,
    input  logic        rx_empty,
    input  logic [7:0]  rx_head,
    output logic        rx_pop,
    output logic [31:0] rd_data,
    output logic        bus_ready,
    output logic        err_overflow,
    output logic        err_underflow
);
    typedef struct packed {
        acc_kind_e   kind;
        logic [1:0]  lane;
        logic        abort;
        logic [31:0] txw;
        logic [31:0] word;
        logic        ovf;
        logic        udf;
    } seq_t;

    seq_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.ovf = 1'b0;
        s_d.udf = 1'b0;
        tx_push = 1'b0;
        rx_pop  = 1'b0;
        tx_byte = s_q.txw[{s_q.lane, 3'b000} +: 8];
        unique case (s_q.kind)
            ACC_IDLE: begin
                if (wr_req) begin
                    s_d.kind  = ACC_WRITE;
                    s_d.lane  = 2'd0;
                    s_d.abort = 1'b0;
                    s_d.txw   = wr_data;
                end else if (rd_req) begin
                    s_d.kind  = ACC_READ;
                    s_d.lane  = 2'd0;
                    s_d.abort = 1'b0;
                    s_d.word  = '0;
                end
            end
            ACC_WRITE: begin
                if (!s_q.abort) begin
                    if (tx_full) begin
                        s_d.abort = 1'b1;
                        s_d.ovf   = 1'b1;
                    end else begin
                        tx_push = 1'b1;
                    end
                end
                s_d.lane = s_q.lane + 2'd1;
                if (s_q.lane == 2'd3) s_d.kind = ACC_IDLE;
            end
            ACC_READ: begin
                if (!s_q.abort) begin
                    if (rx_empty) begin
                        s_d.abort = 1'b1;
                        s_d.udf   = 1'b1;
                    end else begin
                        rx_pop = 1'b1;
                        s_d.word[{s_q.lane, 3'b000} +: 8] = rx_head;
                    end
                end
                s_d.lane = s_q.lane + 2'd1;
                if (s_q.lane == 2'd3) s_d.kind = ACC_IDLE;
            end
            default: s_d.kind = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{kind: ACC_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign bus_ready     = (s_q.kind == ACC_IDLE);
    assign rd_data       = s_q.word;
    assign err_overflow  = s_q.ovf;
    assign err_underflow = s_q.udf;

    // R9
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ready && (wr_req || rd_req)) |=> !bus_ready);

    // R9
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_ready && s_q.lane == 2'd3) |=> bus_ready);

    // R3
    ovf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_overflow |=> !err_overflow);

    // R5
    udf_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_underflow |=> !err_underflow);
endmodule

// File: rtl/spi_word_port.sv
`timescale 1ns/1ps
module spi_word_port #(
    parameter  int DEPTH = 256,
    parameter  int WORDW = 8,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_tx,
    input  logic             flush_rx,
    input  logic             wr_req,
    input  logic [31:0]      wr_data,
    input  logic             rd_req,
    output logic [31:0]      rd_data,
    output logic             bus_ready,
    input  logic             tx_pop,
    output logic [7:0]       tx_byte,
    input  logic             rx_push,
    input  logic [7:0]       rx_byte,
    output logic             tx_full,
    output logic             tx_empty,
    output logic             rx_full,
    output logic             rx_empty,
    output logic [WORDW-1:0] tx_words,
    output logic [WORDW-1:0] rx_words,
    output logic             err_overflow,
    output logic             err_underflow
);
    logic          seq_tx_push, seq_rx_pop;
    logic [7:0]    seq_tx_byte, rx_head;
    logic [CW-1:0] lvl [2];

    spi_word_seq u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_req       (wr_req),
        .wr_data      (wr_data),
        .rd_req       (rd_req),
        .tx_full      (tx_full),
        .tx_push      (seq_tx_push),
        .tx_byte      (seq_tx_byte),
        .rx_empty     (rx_empty),
        .rx_head      (rx_head),
        .rx_pop       (seq_rx_pop),
        .rd_data      (rd_data),
        .bus_ready    (bus_ready),
        .err_overflow (err_overflow),
        .err_underflow(err_underflow)
    );

    spi_byte_ring #(.DEPTH(DEPTH)) u_tx_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_tx),
        .push     (seq_tx_push),
        .push_byte(seq_tx_byte),
        .pop      (tx_pop),
        .head_byte(tx_byte),
        .level    (lvl[0]),
        .full     (tx_full),
        .empty    (tx_empty)
    );

    spi_byte_ring #(.DEPTH(DEPTH)) u_rx_ring (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush_rx),
        .push     (rx_push),
        .push_byte(rx_byte),
        .pop      (seq_rx_pop),
        .head_byte(rx_head),
        .level    (lvl[1]),
        .full     (rx_full),
        .empty    (rx_empty)
    );

    logic [WORDW-1:0] words [2];
    for (genvar g = 0; g < 2; g++) begin : g_words
        logic [CW:0] ext;
        assign ext      = {1'b0, lvl[g]} + (CW+1)'(3);
        assign words[g] = WORDW'(ext >> 2);
    end
    assign tx_words = words[0];
    assign rx_words = words[1];

    // R8
    tx_words_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> (tx_words == '0));

    // R8
    rx_words_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_empty |-> (rx_words == '0));
endmodule

// File: tb/sim_spi_word_port.sv
`timescale 1ns/1ps
module sim_spi_word_port;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush_tx = 0, flush_rx = 0, wr_req = 0, rd_req = 0;
    logic        tx_pop = 0, rx_push = 0;
    logic [31:0] wr_data = '0;
    logic [7:0]  rx_byte = '0;
    logic [31:0] rd_data;
    logic        bus_ready, tx_full, tx_empty, rx_full, rx_empty;
    logic [7:0]  tx_byte, tx_words, rx_words;
    logic        err_overflow, err_underflow;

    spi_word_port #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .flush_tx(flush_tx), .flush_rx(flush_rx),
        .wr_req(wr_req), .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data),
        .bus_ready(bus_ready), .tx_pop(tx_pop), .tx_byte(tx_byte),
        .rx_push(rx_push), .rx_byte(rx_byte), .tx_full(tx_full),
        .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .tx_words(tx_words), .rx_words(rx_words),
        .err_overflow(err_overflow), .err_underflow(err_underflow)
    );

    always #10 clk = ~clk;

    int checks = 0, failures = 0;
    int ovf_seen = 0, udf_seen = 0, ovf_exp = 0, udf_exp = 0;
    int cyc = 0;
    bit done = 0;
    logic [7:0] txq[$];
    logic [7:0] rxq[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    always @(negedge clk) if (rst_n) begin
        if (err_overflow)  ovf_seen++;
        if (err_underflow) udf_seen++;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1;
            failures++;
            checks++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic status(input string req);
        int tn = txq.size();
        int rn = rxq.size();
        chk(tx_words == 8'((tn + 3) / 4), req, "tx_words", tx_words, (tn + 3) / 4);
        chk(rx_words == 8'((rn + 3) / 4), req, "rx_words", rx_words, (rn + 3) / 4);
        chk(tx_empty == (tn == 0), req, "tx_empty", tx_empty, tn == 0);
        chk(tx_full == (tn == DEPTH), req, "tx_full", tx_full, tn == DEPTH);
        chk(rx_empty == (rn == 0), req, "rx_empty", rx_empty, rn == 0);
        chk(rx_full == (rn == DEPTH), req, "rx_full", rx_full, rn == DEPTH);
    endtask

    task automatic wait_ready(input bit noise);
        int lows = 0;
        while (!bus_ready) begin
            lows++;
            rd_req = noise && (lows < 4);
            @(negedge clk);
        end
        rd_req = 0;
        chk(lows == 4, "R9", "busy cycles", lows, 4);
        @(negedge clk);
    endtask

    task automatic do_write(input logic [31:0] w, input bit noise, input bit both);
        bit stop = 0;
        int rn = rxq.size();
        @(negedge clk);
        wr_req = 1; wr_data = w; rd_req = both;
        @(negedge clk);
        wr_req = 0; rd_req = 0;
        for (int i = 0; i < 4; i++) begin
            if (!stop && txq.size() < DEPTH) txq.push_back(w[8*i +: 8]);
            else if (!stop) begin stop = 1; ovf_exp++; end
        end
        wait_ready(noise);
        chk(ovf_seen == ovf_exp, "R3", "overflow pulses", ovf_seen, ovf_exp);
        if (noise || both)
            chk(rx_words == 8'((rn + 3) / 4), both ? "R10" : "R9",
                "rx untouched", rx_words, (rn + 3) / 4);
    endtask

    task automatic do_read(input string req);
        logic [31:0] exp = '0;
        bit stop = 0;
        @(negedge clk);
        rd_req = 1;
        @(negedge clk);
        rd_req = 0;
        for (int i = 0; i < 4; i++) begin
            if (!stop && rxq.size() > 0) exp[8*i +: 8] = rxq.pop_front();
            else if (!stop) begin stop = 1; udf_exp++; end
        end
        wait_ready(0);
        chk(rd_data == exp, req, "rd_data", rd_data, exp);
        chk(udf_seen == udf_exp, "R5", "underflow pulses", udf_seen, udf_exp);
    endtask

    task automatic push_rx(input logic [7:0] b);
        @(negedge clk);
        rx_push = 1; rx_byte = b;
        @(negedge clk);
        rx_push = 0;
        if (rxq.size() < DEPTH) rxq.push_back(b);
    endtask

    task automatic pop_tx(input string req);
        @(negedge clk);
        if (txq.size() > 0) begin
            chk(tx_byte == txq[0], req, "tx_byte", tx_byte, txq[0]);
            void'(txq.pop_front());
        end
        tx_pop = 1;
        @(negedge clk);
        tx_pop = 0;
    endtask

    task automatic flush_both();
        @(negedge clk);
        flush_tx = 1; flush_rx = 1;
        @(negedge clk);
        flush_tx = 0; flush_rx = 0;
        txq.delete(); rxq.delete();
        status("R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        status("R1");
        chk(bus_ready == 1, "R1", "bus_ready", bus_ready, 1);
        chk(err_overflow == 0 && err_underflow == 0, "R1", "pulses",
            {err_overflow, err_underflow}, 0);

        // R2 byte order and R8 depth after partial drain
        do_write(32'h44332211, 0, 0);
        status("R8");
        for (int i = 0; i < 4; i++) begin
            pop_tx("R2");
            status("R8");
        end

        // R3 overflow at every alignment of the last word
        for (int k = 0; k <= 4; k++) begin
            flush_both();
            for (int j = 0; j < 4; j++) do_write(32'h03020100 + 32'h04040404 * j, 0, 0);
            status("R3");
            for (int p = 0; p < k; p++) pop_tx("R2");
            do_write(32'hD4C3B2A1 ^ k, 0, 0);
            status("R3");
            while (txq.size() > 0) pop_tx("R3");
            status("R3");
        end

        // R8 depth sweep, R6 full cleared by a read, R4 assembly order
        flush_both();
        for (int n = 1; n <= DEPTH; n++) begin
            push_rx(8'(8'h50 + n));
            status("R8");
        end
        push_rx(8'hEE);
        status("R6");
        do_read("R4");
        status("R6");
        while (rxq.size() > 0) do_read("R4");
        status("R4");

        // R5 underflow with 0..4 bytes present
        for (int k = 0; k <= 4; k++) begin
            for (int j = 0; j < k; j++) push_rx(8'(8'hA0 + 16 * k + j));
            do_read("R5");
            status("R5");
        end

        // R7 flush with content in both queues
        for (int j = 0; j < 6; j++) push_rx(8'(j + 1));
        do_write(32'h11223344, 0, 0);
        status("R7");
        flush_both();

        // R9 reads raised while busy are ignored; R10 write wins a tie
        for (int j = 0; j < 5; j++) push_rx(8'(8'hC0 + j));
        do_write(32'hCAFEF00D, 1, 0);
        status("R9");
        do_write(32'h0BADBEEF, 0, 1);
        status("R10");
        while (txq.size() > 0) pop_tx("R10");
        do_read("R10");
        status("R10");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule